// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Byte Store Controller

This block sits behind a serial programming front end that has already decoded each instruction into a parallel strobe. It keeps a 64-byte nonvolatile store, modelled as registers, arranged as 16 pages of 4 bytes. The host has two ways to write. It can write one byte directly, giving the address and the data at once; the old value is treated as erased and replaced. It can also stage up to four bytes in a one-page holding buffer and then commit that buffer to a chosen page. A commit changes only the byte positions staged since the previous commit; the other bytes of the page keep their contents.

Every accepted write locks the store for a fixed minimum wait, set as a clock-cycle count, which models the cell programming time. The host can poll a status command, or watch the `ready` pin, instead of waiting out the full delay. A write or commit that arrives during the lock is dropped and sets a sticky error flag. Reads, status polls and staging loads are still served during the lock.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset every stored byte reads 0xFF, `ready` is 1, `wr_err` is 0 and no staging position is marked loaded.
- R2: A load command writes `wdata` into staging position `addr[1:0]` and marks that position loaded. Bits `addr[5:2]` are ignored. A load is accepted while busy.
- R3: A commit command targets page `addr[5:2]`. It writes the staged byte into store address `{addr[5:2], k}` for every loaded position k, and leaves the other bytes of that page unchanged. Acceptance of a commit clears every loaded mark.
- R4: A byte-write command stores `wdata` at store address `addr`. The other 63 bytes are unchanged.
- R5: After an accepted byte write, or an accepted commit with at least one loaded position, `ready` is 0 for exactly WAIT_CYC cycles, starting in the cycle after acceptance. A write issued in the first cycle that `ready` is 1 again is accepted.
- R6: A poll command makes `rvalid` 1 in the next cycle, with `rdata` = 0x01 if busy and 0x00 if ready.
- R7: A read command makes `rvalid` 1 in the next cycle, with `rdata` holding the byte at `addr`. A read in the same cycle as an accepted write to that address returns the value from before the write.
- R8: A byte write or commit issued while `ready` is 0 changes no stored byte, starts no new wait and clears no loaded mark. It sets `wr_err`, which stays 1 until reset.
- R9: A commit accepted while no position is loaded writes nothing and leaves `ready` at 1.
- R10: When several write-group strobes are high in one cycle, only the highest one acts, in the order commit, then byte write, then load. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_load | input | 1 | Stage one byte into the holding buffer |
| cmd_commit | input | 1 | Commit the staged bytes to a page |
| cmd_wbyte | input | 1 | Write one byte directly |
| cmd_read | input | 1 | Read one byte |
| cmd_poll | input | 1 | Return the busy status on `rdata` |
| addr | input | 6 | Byte address: page in the upper 4 bits, position in the lower 2 |
| wdata | input | 8 | Data for load and byte-write commands |
| rdata | output | 8 | Read data or status, registered |
| rvalid | output | 1 | `rdata` is valid for the command of the previous cycle |
| ready | output | 1 | 1 when no write wait is in progress |
| wr_err | output | 1 | Sticky flag: a write or commit was dropped because the store was busy |

## Verification
Three pairs of functions can fall in the same cycle, and each is provoked on purpose.

- **Read and accepted write.** A read is sent together with an accepted byte write to the same address. It is judged correct only if it returns the value from before the write, with the new value visible on the next read.
- **End of the busy wait and a new write.** A byte write is issued in the last busy cycle, and again in the first ready cycle. The first must be dropped with `wr_err` set and the second must be stored.
- **Commit and load.** A commit is raised together with a load. A later commit with no loads in between must leave `ready` high, which shows that the load was dropped.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LOAD   = 2'd1,
    OP_COMMIT = 2'd2,
    OP_BYTE   = 2'd3
  } wr_op_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/eepc_stage_buf.sv
module eepc_stage_buf #(
  parameter int OFS_W  = 2,
  parameter int DATA_W = 8,
  localparam int PB    = 1 << OFS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [OFS_W-1:0]     load_ofs,
  input  logic [DATA_W-1:0]    load_data,
  input  logic                 clr,
  output logic [PB-1:0]        mask,
  output logic [PB*DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (clr) begin
      mask <= '0;
    end else if (load_en) begin
      mask[load_ofs] <= 1'b1;
    end
  end

  for (genvar k = 0; k < PB; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data[k*DATA_W +: DATA_W] <= '0;
      end else if (load_en && load_ofs == OFS_W'(k)) begin
        data[k*DATA_W +: DATA_W] <= load_data;
      end
    end
  end

  // R3
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0));

  // R2
  load_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !clr) |=> mask[$past(load_ofs)]);
endmodule

// File: rtl/eepc_busy_timer.sv
module eepc_busy_timer #(
  parameter int WAIT_CYC = 1125000,
  localparam int CW = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CW'(WAIT_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy_o = (cnt != '0);

  // R5
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_o);

  // R5
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_o);

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(cnt) == CW'(1)));
endmodule

// File: rtl/eepc_array.sv
module eepc_array #(
  parameter int ADDR_W = 6,
  parameter int OFS_W  = 2,
  parameter int DATA_W = 8,
  localparam int PB    = 1 << OFS_W,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PG_W  = ADDR_W - OFS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [PG_W-1:0]      wr_page,
  input  logic [PB-1:0]        wr_be,
  input  logic [PB*DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam int PG = g / PB;
    localparam int BY = g % PB;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[g] <= DATA_W'(eepc_pkg::ERASED_BYTE);
      end else if (we && wr_page == PG_W'(PG) && wr_be[BY]) begin
        mem[g] <= wr_data[BY*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
  parameter int ADDR_W   = 6,
  parameter int OFS_W    = 2,
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 1125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic              cmd_commit,
  input  logic              cmd_wbyte,
  input  logic              cmd_read,
  input  logic              cmd_poll,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              ready,
  output logic              wr_err
);
  import eepc_pkg::*;

  localparam int PB   = 1 << OFS_W;
  localparam int PG_W = ADDR_W - OFS_W;

  function automatic logic [PB-1:0] ofs_onehot(input logic [OFS_W-1:0] o);
    ofs_onehot = PB'(1) << o;
  endfunction

  function automatic logic [PB*DATA_W-1:0] spread(input logic [DATA_W-1:0] b);
    spread = {PB{b}};
  endfunction

  wr_op_e              op;
  logic                busy;
  logic [PB-1:0]       stg_mask;
  logic [PB*DATA_W-1:0] stg_data;
  logic [DATA_W-1:0]   arr_rd;
  logic [PG_W-1:0]     page_sel;
  logic [OFS_W-1:0]    ofs_sel;

  logic evt_reject, evt_commit_ok, evt_commit_real, evt_byte_ok;
  logic tmr_start, mask_clr, load_en;
  logic [PB-1:0]        arr_be;
  logic [PB*DATA_W-1:0] arr_data;

  assign page_sel = addr[ADDR_W-1:OFS_W];
  assign ofs_sel  = addr[OFS_W-1:0];

  always_comb begin
    if (cmd_commit)      op = OP_COMMIT;
    else if (cmd_wbyte)  op = OP_BYTE;
    else if (cmd_load)   op = OP_LOAD;
    else                 op = OP_NONE;
  end

  assign evt_reject      = busy && (op == OP_COMMIT || op == OP_BYTE);
  assign evt_commit_ok   = !busy && (op == OP_COMMIT);
  assign evt_commit_real = evt_commit_ok && (stg_mask != '0);
  assign evt_byte_ok     = !busy && (op == OP_BYTE);
  assign tmr_start       = evt_commit_real || evt_byte_ok;
  assign mask_clr        = evt_commit_ok;
  assign load_en         = (op == OP_LOAD);
  assign arr_be          = evt_byte_ok ? ofs_onehot(ofs_sel) : stg_mask;
  assign arr_data        = evt_byte_ok ? spread(wdata) : stg_data;

  eepc_stage_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) stage_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_ofs(ofs_sel),
    .load_data(wdata), .clr(mask_clr), .mask(stg_mask), .data(stg_data)
  );

  eepc_busy_timer #(.WAIT_CYC(WAIT_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy_o(busy)
  );

  eepc_array #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) array_i (
    .clk(clk), .rst_n(rst_n), .we(tmr_start), .wr_page(page_sel),
    .wr_be(arr_be), .wr_data(arr_data), .rd_addr(addr), .rd_data(arr_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else if (cmd_read) begin
      rdata  <= arr_rd;
      rvalid <= 1'b1;
    end else if (cmd_poll) begin
      rdata  <= DATA_W'(busy);
      rvalid <= 1'b1;
    end else begin
      rvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          wr_err <= 1'b0;
    else if (evt_reject) wr_err <= 1'b1;
  end

  assign ready = !busy;

  // R8
  reject_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reject |=> wr_err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

  // R9
  empty_commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_commit_ok && stg_mask == '0) |=> ready);

  // R7
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_read || cmd_poll) |=> rvalid);

  // R10
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({evt_commit_ok, evt_byte_ok, load_en, evt_reject}) <= 1);
endmodule

// File: tb/eeprom_page_ctrl_tb_top.sv
module eeprom_page_ctrl_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_load = 0, cmd_commit = 0, cmd_wbyte = 0, cmd_read = 0, cmd_poll = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rvalid, ready, wr_err;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;
  logic [7:0] model [64];

  always #4 clk = ~clk;

  eeprom_page_ctrl #(.WAIT_CYC(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_commit(cmd_commit),
    .cmd_wbyte(cmd_wbyte), .cmd_read(cmd_read), .cmd_poll(cmd_poll),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .ready(ready), .wr_err(wr_err)
  );

  function automatic logic [7:0] dat(input int a, input int s);
    dat = 8'((a * 29 + s * 71 + 3) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input bit ld, input bit cm, input bit wb, input bit rd,
                     input bit pl, input int a, input int d);
    cmd_load = ld; cmd_commit = cm; cmd_wbyte = wb; cmd_read = rd; cmd_poll = pl;
    addr = 6'(a); wdata = 8'(d);
    @(negedge clk);
    cmd_load = 0; cmd_commit = 0; cmd_wbyte = 0; cmd_read = 0; cmd_poll = 0;
  endtask

  task automatic rd_chk(input string req, input int a);
    cmd(0, 0, 0, 1, 0, a, 0);
    chk(req, {rvalid, rdata}, {1'b1, model[a]});
  endtask

  task automatic wait_ready();
    int guard = 0;
    forever begin
      cmd(0, 0, 0, 0, 1, 0, 0);
      if (rdata == 8'h00) break;
      guard++;
      if (guard > 4 * W) begin
        chk("R6 poll never ready", 1, 0);
        break;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 ready", ready, 1);
    chk("R1 err", wr_err, 0);
    for (int a = 0; a < 64; a++) rd_chk("R1 erased", a);
    cmd(0, 1, 0, 0, 0, 0, 0);
    chk("R1 mask empty", ready, 1);

    // R6 poll while ready
    cmd(0, 0, 0, 0, 1, 0, 0);
    chk("R6 poll idle", {rvalid, rdata}, {1'b1, 8'h00});

    // R4 single byte sweep
    for (int a = 0; a < 64; a++) begin
      cmd(0, 0, 1, 0, 0, a, dat(a, 1));
      model[a] = dat(a, 1);
      if (a == 0) begin
        cmd(0, 0, 0, 0, 1, 0, 0);
        chk("R6 poll busy", {rvalid, rdata}, {1'b1, 8'h01});
      end
      wait_ready();
    end
    for (int a = 0; a < 64; a++) rd_chk("R4 byte write", a);

    // R3 / R9 page commit over all masks
    for (int p = 0; p < 16; p++) begin
      for (int b = 0; b < 4; b++) begin
        if (p[b]) begin
          cmd(1, 0, 0, 0, 0, ((15 - p) << 2) | b, dat(p * 4 + b, 2));
          model[p * 4 + b] = dat(p * 4 + b, 2);
        end
      end
      cmd(0, 1, 0, 0, 0, (p << 2) | (p & 3), 0);
      if (p == 0) chk("R9 empty commit ready", ready, 1);
      else chk("R5 commit busy", ready, 0);
      wait_ready();
      for (int b = 0; b < 4; b++) rd_chk("R3 masked commit", p * 4 + b);
    end
    cmd(0, 1, 0, 0, 0, 5 << 2, 0);
    chk("R3 mask cleared", ready, 1);

    // R5 busy length
    begin
      int n = 0;
      cmd(0, 0, 1, 0, 0, 9, 8'h5A);
      model[9] = 8'h5A;
      while (!ready && n < 4 * W) begin
        n++;
        @(negedge clk);
      end
      chk("R5 busy cycles", n, W);
    end
    cmd(0, 0, 1, 0, 0, 10, 8'hA5);
    model[10] = 8'hA5;
    chk("R5 accepted at first ready", ready, 0);
    chk("R5 no err", wr_err, 0);
    wait_ready();
    rd_chk("R5 boundary write", 10);

    // R7 read during write, same address
    cmd(0, 0, 1, 1, 0, 11, 8'h3C);
    chk("R7 read old", {rvalid, rdata}, {1'b1, model[11]});
    model[11] = 8'h3C;
    wait_ready();
    rd_chk("R7 read new", 11);

    // R10 commit with load in same cycle
    cmd(1, 0, 0, 0, 0, 0, 8'h77);
    cmd(1, 1, 0, 0, 0, (3 << 2) | 1, 8'h88);
    model[12] = 8'h77;
    wait_ready();
    rd_chk("R10 commit wins", 12);
    rd_chk("R10 load dropped", 13);
    cmd(0, 1, 0, 0, 0, 4 << 2, 0);
    chk("R10 load left no mark", ready, 1);
    cmd(1, 0, 1, 0, 0, 20, 8'h99);
    model[20] = 8'h99;
    wait_ready();
    rd_chk("R10 byte wins", 20);
    cmd(0, 1, 0, 0, 0, 4 << 2, 0);
    chk("R10 load dropped vs byte", ready, 1);

    // R8 / R5 reject in last busy cycle, R2 load while busy
    cmd(0, 0, 1, 0, 0, 30, 8'h11);
    model[30] = 8'h11;
    cmd(1, 0, 0, 0, 0, 2, 8'hC3);
    cmd(0, 1, 0, 0, 0, 6 << 2, 0);
    cmd(0, 0, 0, 1, 0, 7, 0);
    chk("R8 read while busy", {rvalid, rdata}, {1'b1, model[7]});
    repeat (W - 4) @(negedge clk);
    chk("R5 last busy cycle", ready, 0);
    cmd(0, 0, 1, 0, 0, 7, 8'hEE);
    chk("R8 err set", wr_err, 1);
    chk("R8 ready after reject", ready, 1);
    rd_chk("R8 byte ignored", 7);
    for (int b = 0; b < 4; b++) rd_chk("R8 commit ignored", 24 + b);
    cmd(0, 1, 0, 0, 0, 6 << 2, 0);
    model[26] = 8'hC3;
    chk("R2 load while busy kept", ready, 0);
    wait_ready();
    for (int b = 0; b < 4; b++) rd_chk("R2 staged commit", 24 + b);
    chk("R8 err sticky", wr_err, 1);

    do_reset();
    chk("R1 err cleared", wr_err, 0);
    rd_chk("R1 erased again", 30);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule